// File: doc/BRIEF.md
# Indirect Configuration Register Host Port

This block lets a host processor reach a large bank of 8-bit internal configuration registers through a small parallel bus. The bus has a three-bit location address, chip-select, read and write strobes. The host never addresses an internal register directly. It first loads an index that names the internal register, then reads or writes a data location. The block turns each data access into a single-cycle strobe on a 16-bit internal address bus and an 8-bit internal data bus. The register bank on that bus sits outside the block.

The bus width is chosen by a static strap that is sampled during reset. In narrow (8-bit) mode the index is assembled from two byte locations, one for each half. In wide (16-bit) mode a single write supplies the whole index. The index stays where it is after data accesses, so several data writes in a row all land on the same internal register. Location 3 is kept for a frame data port that is not part of this path. That location, and every location above it, is inert.

Top module: `cfg_window_port`

## Requirements
- R1: While reset is low at a clock edge, the index clears to zero. After that edge, reg_addr_o, reg_wr_o, reg_rd_o and host_rdata_o are all zero.
- R2: In narrow mode (strap 0), a write to location 0 loads index bits 7:0 and a write to location 1 loads index bits 15:8, both from host_wdata_i[7:0]. Each write leaves the other byte as it was. reg_addr_o shows the index one cycle after the access is accepted.
- R3: In wide mode (strap 1), a write to location 0 loads all 16 index bits from host_wdata_i. A write to location 1 is ignored.
- R4: A write accepted at location 2 produces exactly one reg_wr_o pulse, one clock long, in the cycle after acceptance. During that pulse reg_wdata_o equals host_wdata_i[7:0] and reg_addr_o equals the current index.
- R5: Data reads and data writes never change the index.
- R6: A read accepted at location 2 produces one reg_rd_o pulse, one clock long, in the cycle after acceptance. At the end of that cycle host_rdata_o captures {8'h00, reg_rdata_i} and holds it until the next read.
- R7: An access is accepted only on the clock where its strobe is first seen high with chip-select high. A strobe held high for several cycles performs one access. If both strobes rise together, only the write is performed.
- R8: Writes to locations 3 through 7 change no state. Reads from those locations return zero and raise no reg_rd_o.
- R9: Reads of index locations return the index. In narrow mode, location 0 returns {8'h00, index[7:0]} and location 1 returns {8'h00, index[15:8]}. In wide mode, location 0 returns the full index and location 1 returns zero. Read data appears two edges after the accepting edge, as in R6.
- R10: The bus-width mode is captured from wide_mode_i while reset is low. Changes on wide_mode_i after reset have no effect.
- R11: Strobes seen while host_sel_i is low cause no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode_i | input | 1 | Bus width strap: 1 selects wide (16-bit) mode, 0 selects narrow (8-bit) mode; sampled during reset |
| host_sel_i | input | 1 | Host chip-select, active high |
| host_rd_i | input | 1 | Host read strobe, active high |
| host_wr_i | input | 1 | Host write strobe, active high |
| host_addr_i | input | 3 | Host location address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, registered |
| reg_addr_o | output | 16 | Internal register address (the index) |
| reg_wdata_o | output | 8 | Internal register write data |
| reg_wr_o | output | 1 | Internal write strobe, one cycle long |
| reg_rd_o | output | 1 | Internal read strobe, one cycle long |
| reg_rdata_i | input | 8 | Internal register read data, valid during reg_rd_o |

## Verification
The index register drives reg_addr_o directly. A wrong index byte, or a byte loaded from the wrong half of the data bus, therefore appears on that port one cycle after the offending write. It shows up again two edges after any index readback. A broken edge detector or a broken location decode shows up as an extra or a missing reg_wr_o or reg_rd_o pulse in the cycle that follows acceptance. A wrong mode capture changes how the very next location-0 write is interpreted. The bench checks each of these ports at the exact cycle the requirements fix, after both directed and seeded random access sequences in both modes. It compares what it reads back against a shadow copy of every value it has written.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
// Package: location codes and default sizes shared by the host port modules.
// Assumes the host location address is three bits wide.
package cfgwin_pkg;
    localparam int HOST_AW = 3;
    localparam logic [HOST_AW-1:0] LOC_IDX_LO = 3'd0;
    localparam logic [HOST_AW-1:0] LOC_IDX_HI = 3'd1;
    localparam logic [HOST_AW-1:0] LOC_DATA   = 3'd2;
    localparam logic [HOST_AW-1:0] LOC_FRAME  = 3'd3;
endpackage

// File: rtl/cfgwin_host_sync.sv
`timescale 1ns/1ps
// Module: cfgwin_host_sync
// Turns level host strobes into single-cycle accept pulses.
// Assumes: strobes are already synchronous to clk; write wins a tie.
module cfgwin_host_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic rd_i,
    input  logic wr_i,
    output logic wr_acc_o,
    output logic rd_acc_o
);
    logic wr_q;
    logic rd_q;
    logic wr_rise;
    logic rd_rise;

    // Remember last strobe levels so a held strobe is taken only once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_i;
            rd_q <= rd_i;
        end
    end

    // Accept on the first selected high sample; write has priority.
    always_comb begin
        wr_rise  = sel_i & wr_i & ~wr_q;
        rd_rise  = sel_i & rd_i & ~rd_q;
        wr_acc_o = wr_rise;
        rd_acc_o = rd_rise & ~wr_rise;
    end
endmodule

// File: rtl/cfgwin_index.sv
`timescale 1ns/1ps
// Module: cfgwin_index
// Holds the internal register index. Loaded bytewise in narrow mode and
// whole in wide mode.
// Assumes: IDX_W is even and HOST_W >= IDX_W.
module cfgwin_index #(
    parameter int IDX_W  = 16,
    parameter int HOST_W = 16,
    parameter int AW     = cfgwin_pkg::HOST_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              wr_acc_i,
    input  logic [AW-1:0]     loc_i,
    input  logic [HOST_W-1:0] wdata_i,
    output logic [IDX_W-1:0]  idx_o
);
    import cfgwin_pkg::*;
    localparam int HALF_W = IDX_W / 2;

    logic [HALF_W-1:0] idx_lo_q;
    logic [HALF_W-1:0] idx_hi_q;

    // Load index halves according to bus mode and location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo_q <= '0;
            idx_hi_q <= '0;
        end else if (wr_acc_i) begin
            if (wide_i) begin
                if (loc_i == LOC_IDX_LO) begin
                    idx_lo_q <= wdata_i[HALF_W-1:0];
                    idx_hi_q <= wdata_i[IDX_W-1:HALF_W];
                end
            end else begin
                if (loc_i == LOC_IDX_LO) idx_lo_q <= wdata_i[HALF_W-1:0];
                if (loc_i == LOC_IDX_HI) idx_hi_q <= wdata_i[HALF_W-1:0];
            end
        end
    end

    assign idx_o = {idx_hi_q, idx_lo_q};
endmodule

// File: rtl/cfgwin_access.sv
`timescale 1ns/1ps
// Module: cfgwin_access
// Issues internal write/read strobes and forms registered host read data.
// Assumes: internal read data is valid in the cycle reg_rd_o is high.
module cfgwin_access #(
    parameter int IDX_W  = 16,
    parameter int HOST_W = 16,
    parameter int REG_W  = 8,
    parameter int AW     = cfgwin_pkg::HOST_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              wr_acc_i,
    input  logic              rd_acc_i,
    input  logic [AW-1:0]     loc_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [REG_W-1:0]  reg_rdata_i,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [REG_W-1:0]  reg_wdata_o,
    output logic [HOST_W-1:0] host_rdata_o
);
    import cfgwin_pkg::*;
    localparam int HALF_W = IDX_W / 2;

    logic              rd_pend_q;
    logic [AW-1:0]     rd_loc_q;
    logic [HOST_W-1:0] rd_mux;

    // Launch one-cycle internal strobes for accepted data-location accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
            reg_wdata_o <= '0;
        end else begin
            reg_wr_o <= wr_acc_i && (loc_i == LOC_DATA);
            reg_rd_o <= rd_acc_i && (loc_i == LOC_DATA);
            if (wr_acc_i && (loc_i == LOC_DATA)) reg_wdata_o <= wdata_i;
        end
    end

    // Remember which location a pending read targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_loc_q  <= '0;
        end else begin
            rd_pend_q <= rd_acc_i;
            if (rd_acc_i) rd_loc_q <= loc_i;
        end
    end

    // Select read data by location and bus mode.
    always_comb begin
        rd_mux = '0;
        unique case (rd_loc_q)
            LOC_IDX_LO: begin
                if (wide_i) rd_mux[IDX_W-1:0]  = idx_i;
                else        rd_mux[HALF_W-1:0] = idx_i[HALF_W-1:0];
            end
            LOC_IDX_HI: begin
                if (!wide_i) rd_mux[HALF_W-1:0] = idx_i[IDX_W-1:HALF_W];
            end
            LOC_DATA:   rd_mux[REG_W-1:0] = reg_rdata_i;
            default:    rd_mux = '0;
        endcase
    end

    // Capture host read data one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)         host_rdata_o <= '0;
        else if (rd_pend_q) host_rdata_o <= rd_mux;
    end
endmodule

// File: rtl/cfg_window_port.sv
`timescale 1ns/1ps
// Module: cfg_window_port (top)
// Host-side indirect window onto 8-bit internal configuration registers.
// Assumes: wide_mode_i is static; the internal register bank answers
// combinationally while reg_rd_o is high.
module cfg_window_port #(
    parameter int HOST_W = 16,
    parameter int IDX_W  = 16,
    parameter int REG_W  = 8,
    parameter int AW     = cfgwin_pkg::HOST_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode_i,
    input  logic              host_sel_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [HOST_W-1:0] host_wdata_i,
    output logic [HOST_W-1:0] host_rdata_o,
    output logic [IDX_W-1:0]  reg_addr_o,
    output logic [REG_W-1:0]  reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [REG_W-1:0]  reg_rdata_i
);
    logic mode_q;
    logic wr_acc;
    logic rd_acc;

    // Capture the bus-width strap during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= wide_mode_i;
    end

    cfgwin_host_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (host_sel_i),
        .rd_i     (host_rd_i),
        .wr_i     (host_wr_i),
        .wr_acc_o (wr_acc),
        .rd_acc_o (rd_acc)
    );

    cfgwin_index #(.IDX_W(IDX_W), .HOST_W(HOST_W), .AW(AW)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_i   (mode_q),
        .wr_acc_i (wr_acc),
        .loc_i    (host_addr_i),
        .wdata_i  (host_wdata_i),
        .idx_o    (reg_addr_o)
    );

    cfgwin_access #(.IDX_W(IDX_W), .HOST_W(HOST_W), .REG_W(REG_W), .AW(AW)) u_access (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_i       (mode_q),
        .wr_acc_i     (wr_acc),
        .rd_acc_i     (rd_acc),
        .loc_i        (host_addr_i),
        .wdata_i      (host_wdata_i[REG_W-1:0]),
        .idx_i        (reg_addr_o),
        .reg_rdata_i  (reg_rdata_i),
        .reg_wr_o     (reg_wr_o),
        .reg_rd_o     (reg_rd_o),
        .reg_wdata_o  (reg_wdata_o),
        .host_rdata_o (host_rdata_o)
    );
endmodule

// File: rtl/cfg_window_port_chk.sv
`timescale 1ns/1ps
// Module: cfg_window_port_chk
// Protocol checker for cfg_window_port, attached by bind.
module cfg_window_port_chk #(
    parameter int HOST_W = 16,
    parameter int IDX_W  = 16,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_q,
    input logic              wr_acc,
    input logic              rd_acc,
    input logic [AW-1:0]     host_addr_i,
    input logic [HOST_W-1:0] host_rdata_o,
    input logic [IDX_W-1:0]  reg_addr_o,
    input logic              reg_wr_o,
    input logic              reg_rd_o
);
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    p_wr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> $past(wr_acc && host_addr_i == 3'd2));
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);
    p_rd_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> $past(rd_acc && host_addr_i == 3'd2));
    p_one_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && rd_acc));
    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> $stable(reg_addr_o));
    p_wide_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && wr_acc && host_addr_i == 3'd1) |=> $stable(reg_addr_o));
    p_resv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_acc && host_addr_i >= 3'd3, 2) && $past(rst_n, 2)) |-> host_rdata_o == '0);
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

bind cfg_window_port cfg_window_port_chk #(.HOST_W(HOST_W), .IDX_W(IDX_W), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .wr_acc       (wr_acc),
    .rd_acc       (rd_acc),
    .host_addr_i  (host_addr_i),
    .host_rdata_o (host_rdata_o),
    .reg_addr_o   (reg_addr_o),
    .reg_wr_o     (reg_wr_o),
    .reg_rd_o     (reg_rd_o)
);

// File: tb/cfg_window_port_tb.sv
`timescale 1ns/1ps
// Bench for cfg_window_port: directed corners plus seeded random traffic,
// with an internal register bank model and a shadow of expected contents.
module cfg_window_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] raddr;
    logic [7:0]  rwdata;
    logic        rwr, rrd;
    logic [7:0]  rrdata;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [7:0]  rf     [0:1023];
    logic [7:0]  shadow [0:1023];
    logic [15:0] exp_idx;
    bit          exp_wide;
    int          wr_pulses = 0, rd_pulses = 0;
    logic        s_wr, s_rd, s_wr_after;
    logic [15:0] s_addr;
    logic [7:0]  s_wdata;

    always #2 clk = ~clk;

    cfg_window_port u_dut (
        .clk(clk), .rst_n(rst_n), .wide_mode_i(wide),
        .host_sel_i(sel), .host_rd_i(rd), .host_wr_i(wr),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
        .reg_addr_o(raddr), .reg_wdata_o(rwdata), .reg_wr_o(rwr),
        .reg_rd_o(rrd), .reg_rdata_i(rrdata)
    );

    // Internal register bank model
    always @(posedge clk) begin
        if (rwr) rf[raddr[9:0]] <= rwdata;
        if (rwr) wr_pulses <= wr_pulses + 1;
        if (rrd) rd_pulses <= rd_pulses + 1;
    end
    assign rrdata = rf[raddr[9:0]];

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] loc);
        case (loc)
            3'd0: return exp_wide ? exp_idx : {8'h00, exp_idx[7:0]};
            3'd1: return exp_wide ? 16'h0 : {8'h00, exp_idx[15:8]};
            3'd2: return {8'h00, shadow[exp_idx[9:0]]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic void exp_write(input logic [2:0] loc, input logic [15:0] d);
        if (loc == 3'd0) begin
            if (exp_wide) exp_idx = d; else exp_idx[7:0] = d[7:0];
        end else if (loc == 3'd1) begin
            if (!exp_wide) exp_idx[15:8] = d[7:0];
        end else if (loc == 3'd2) begin
            shadow[exp_idx[9:0]] = d[7:0];
        end
    endfunction

    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        s_wr = rwr; s_addr = raddr; s_wdata = rwdata;
        sel = 0; wr = 0;
        @(negedge clk);
        s_wr_after = rwr;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] q);
        @(negedge clk);
        sel = 1; rd = 1; addr = a;
        @(negedge clk);
        s_rd = rrd;
        sel = 0; rd = 0;
        @(negedge clk);
        q = rdata;
    endtask

    task automatic do_reset(input logic w);
        @(negedge clk);
        rst_n = 0; wide = w; sel = 0; rd = 0; wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        exp_idx = '0; exp_wide = w;
    endtask

    task automatic random_ops(input int n);
        logic [15:0] q;
        for (int i = 0; i < n; i++) begin
            int k = $urandom_range(0, 9);
            logic [2:0] a = (k < 2) ? 3'd0 : (k < 3) ? 3'd1 : (k < 9) ? 3'd2 : 3'($urandom_range(3, 7));
            logic [15:0] d = 16'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                host_write(a, d);
                exp_write(a, d);
                check("R4 random strobe", s_wr, a == 3'd2);
                check("R2/R3 random index", raddr, exp_idx);
            end else begin
                logic [15:0] e = exp_read(a);
                host_read(a, q);
                check("R6/R9 random read", q, e);
                check("R6 random rd strobe", s_rd, a == 3'd2);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] q;
        int base;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 1024; i++) begin
            rf[i] = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
        do_reset(1'b0);
        @(negedge clk);
        check("R1 addr", raddr, 16'h0);
        check("R1 wr", rwr, 1'b0);
        check("R1 rd", rrd, 1'b0);
        check("R1 rdata", rdata, 16'h0);

        // R2: bytewise index in narrow mode
        host_write(3'd0, 16'hAB34); exp_write(3'd0, 16'hAB34);
        check("R2 low byte", raddr, 16'h0034);
        host_write(3'd1, 16'hCD02); exp_write(3'd1, 16'hCD02);
        check("R2 high byte", raddr, 16'h0234);

        // R4 / R5: data writes keep the index
        host_write(3'd2, 16'h77C3); exp_write(3'd2, 16'h77C3);
        check("R4 wr pulse", s_wr, 1'b1);
        check("R4 wr data", s_wdata, 8'hC3);
        check("R4 wr addr", s_addr, 16'h0234);
        check("R4 single cycle", s_wr_after, 1'b0);
        host_write(3'd2, 16'h0019); exp_write(3'd2, 16'h0019);
        check("R5 index kept", raddr, 16'h0234);

        // R6: data read
        base = rd_pulses;
        host_read(3'd2, q);
        check("R6 rd strobe", s_rd, 1'b1);
        check("R6 rdata", q, 16'h0019);
        check("R6 one rd pulse", rd_pulses - base, 1);
        check("R5 index after read", raddr, 16'h0234);

        // R9: index readback in narrow mode
        host_read(3'd0, q); check("R9 narrow lo", q, 16'h0034);
        host_read(3'd1, q); check("R9 narrow hi", q, 16'h0002);

        // R8: reserved locations
        base = wr_pulses;
        host_write(3'd3, 16'hFFFF);
        host_write(3'd6, 16'hEEEE);
        check("R8 no strobe", wr_pulses - base, 0);
        check("R8 index intact", raddr, 16'h0234);
        host_read(3'd3, q); check("R8 read zero", q, 16'h0); check("R8 no rd", s_rd, 1'b0);
        host_read(3'd7, q); check("R8 read7 zero", q, 16'h0);
        host_read(3'd2, q); check("R8 bank intact", q, 16'h0019);

        // R7: held strobe, single access; tie goes to write
        base = wr_pulses;
        @(negedge clk); sel = 1; wr = 1; addr = 3'd2; wdata = 16'h00A5;
        repeat (4) @(negedge clk);
        sel = 0; wr = 0; exp_write(3'd2, 16'h00A5);
        @(negedge clk);
        check("R7 held one pulse", wr_pulses - base, 1);
        base = rd_pulses;
        @(negedge clk); sel = 1; wr = 1; rd = 1; addr = 3'd2; wdata = 16'h003C;
        @(negedge clk); sel = 0; wr = 0; rd = 0; exp_write(3'd2, 16'h003C);
        @(negedge clk);
        check("R7 tie no read", rd_pulses - base, 0);
        host_read(3'd2, q); check("R7 tie wrote", q, 16'h003C);

        // R11: no select, no access
        base = wr_pulses;
        @(negedge clk); sel = 0; wr = 1; addr = 3'd0; wdata = 16'h1111;
        @(negedge clk); addr = 3'd2;
        @(negedge clk); wr = 0;
        @(negedge clk);
        check("R11 no write", wr_pulses - base, 0);
        check("R11 index intact", raddr, 16'h0234);

        random_ops(300);

        // R10 / R3: wide mode
        do_reset(1'b1);
        @(negedge clk); wide = 0;
        check("R1 addr after reset", raddr, 16'h0);
        host_write(3'd0, 16'h8301); exp_write(3'd0, 16'h8301);
        check("R10 strap held / R3 full index", raddr, 16'h8301);
        host_write(3'd1, 16'h00FF);
        check("R3 loc1 ignored", raddr, 16'h8301);
        host_read(3'd1, q); check("R9 wide hi zero", q, 16'h0);
        host_read(3'd0, q); check("R9 wide full", q, 16'h8301);
        host_write(3'd2, 16'hFF6E); exp_write(3'd2, 16'hFF6E);
        check("R4 wide wr addr", s_addr, 16'h8301);
        check("R4 wide wr data", s_wdata, 8'h6E);
        host_read(3'd2, q); check("R6 wide rdata", q, 16'h006E);

        random_ops(300);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule